// File: doc/BRIEF.md
# Dual-Length Serial Word Transmitter

This block turns parallel words into a synchronous serial bit stream, one bit per clock, most significant bit first. Each word can be full length (16 bits) or short (12 bits). Short words are sent as exactly 12 bits, with no padding bits on the line. Both lengths share one 16-bit shift register. A short word is left-aligned into that register. A shift counter is then preset past the unused positions, so it wraps after 12 shifts instead of 16.

An upstream source presents a word on `tx_word`, picks its length with `tx_short` and raises `tx_valid`. The block raises `tx_ack` for one clock at the load instant, and the word is captured on that clock edge. The source may change its inputs right after that edge. When `tx_valid` is held high, words follow each other with no idle bit between them. When no word is offered at the load instant, the line idles at 0 until one arrives.

Top module: `ser_dual_len_tx`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls when no word is offered, `ser_out` is 0 and `tx_ack` is 0, even with `tx_valid` high.
- R2: A word captured with `tx_short` = 0 appears on `ser_out` as bits 15 down to 0, one per clock. Bit 15 is present in the cycle right after the capture edge.
- R3: A word captured with `tx_short` = 1 appears as bits 11 down to 0, one per clock. Bits 15..12 of `tx_word` have no effect on the line.
- R4: With `tx_valid` held high, the next word starts in the clock right after the previous word's last bit. A long word therefore occupies exactly 16 clocks and a short word exactly 12.
- R5: `tx_ack` is high in exactly those clocks where `tx_valid` is high and the block is at a load instant. A load instant is when the block is idle, or when the current word's last bit is on `ser_out`.
- R6: `tx_short` and `tx_word` are used only at the load instant. Changing them while a word is being sent does not alter that word's bits or length.
- R7: When no word is offered at a load instant, `ser_out` is 0 from the following clock on. A word offered later is acknowledged in the first clock in which `tx_valid` is high.
- R8: At each capture, the internal shift counter is preset to 0 for a long word and to 4 for a short word. It counts up by one per shifted bit, and the next load occurs when it wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_word | input | 16 | Parallel word; short words use bits 11..0 |
| tx_short | input | 1 | 1 = send 12-bit word, 0 = send 16-bit word |
| tx_valid | input | 1 | A word is offered |
| tx_ack | output | 1 | Word captured on this clock edge |
| ser_out | output | 1 | Serial data, MSB first, 0 when idle |

## Verification
The stream is checked in four patterns:
- An unbroken run of long words shows the 16-clock period and MSB-first order.
- An unbroken run of short words, each carrying a nonzero upper nibble, shows that bits 15..12 are dropped and that the word period is 12.
- Words alternating in length, with the next word's length and data already on the inputs while the current word shifts, show that the length and data are taken only at the load instant.
- A final run with irregular `tx_valid` gaps and garbage inputs during the gaps shows idle-low behaviour and immediate pickup when data returns.

Every serial bit and every `tx_ack` value is compared against a bit queue that the bench model fills at each expected acknowledge.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
    localparam int WORD_W_DEF  = 16;
    localparam int SHORT_W_DEF = 12;

    typedef enum logic {
        LEN_LONG  = 1'b0,
        LEN_SHORT = 1'b1
    } len_e;

    // Counter preset that makes the counter wrap after the chosen word length
    function automatic int preset_of(len_e len, int word_w, int short_w);
        return (len == LEN_SHORT) ? (word_w - short_w) : 0;
    endfunction
endpackage

// File: rtl/ser_word_align.sv
module ser_word_align
    import ser_tx_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    parameter int SHORT_W = SHORT_W_DEF,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_in,
    input  len_e              len,
    output logic [WORD_W-1:0] aligned,
    output logic [CNT_W-1:0]  preset
);
    localparam int PAD = WORD_W - SHORT_W;

    always_comb begin
        if (len == LEN_SHORT) begin
            // shifting left by the pad drops the unused upper bits
            aligned = word_in << PAD;
        end else begin
            aligned = word_in;
        end
        preset = CNT_W'(preset_of(len, WORD_W, SHORT_W));
    end
endmodule

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             load_point
);
    localparam logic [CNT_W-1:0] LAST = '1;

    always_comb load_point = !busy || (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load_point) begin
            busy <= take;
            cnt  <= preset;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] sreg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ser_dual_len_tx.sv
module ser_dual_len_tx
    import ser_tx_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    parameter int SHORT_W = SHORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_short,
    input  logic              tx_valid,
    output logic              tx_ack,
    output logic              ser_out
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] aligned;
    logic [CNT_W-1:0]  preset;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    logic              load_point;
    logic [WORD_W-1:0] sreg;
    logic              take;
    len_e              len;

    always_comb begin
        len  = tx_short ? LEN_SHORT : LEN_LONG;
        take = tx_valid && load_point;
    end

    ser_word_align #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_align (
        .word_in (tx_word),
        .len     (len),
        .aligned (aligned),
        .preset  (preset)
    );

    ser_bit_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .preset     (preset),
        .cnt        (cnt),
        .busy       (busy),
        .load_point (load_point)
    );

    ser_shift_reg #(.WORD_W(WORD_W)) u_sreg (
        .clk   (clk),
        .rst   (rst),
        .load  (take),
        .shift (busy),
        .din   (aligned),
        .sreg  (sreg)
    );

    always_comb begin
        tx_ack  = !rst && take;
        ser_out = busy && sreg[WORD_W-1];
    end
endmodule

// File: rtl/ser_dual_len_tx_chk.sv
module ser_dual_len_tx_chk #(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 12,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_short,
    input logic              tx_valid,
    input logic              tx_ack,
    input logic              ser_out,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt,
    input logic [WORD_W-1:0] sreg
);
    localparam logic [CNT_W-1:0] LAST  = '1;
    localparam logic [CNT_W-1:0] SHORT_PRE = CNT_W'(WORD_W - SHORT_W);

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_out);

    p_ack_at_load_r5: assert property (@(posedge clk) disable iff (rst)
        tx_ack |-> (tx_valid && (!busy || cnt == LAST)));

    p_no_missed_load_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !busy) |-> tx_ack);

    p_preset_short_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && tx_short) |=> (busy && cnt == SHORT_PRE));

    p_preset_long_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && !tx_short) |=> (busy && cnt == '0));

    p_count_up_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

    p_shift_msb_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> (sreg == {$past(sreg[WORD_W-2:0]), 1'b0}));
endmodule

bind ser_dual_len_tx ser_dual_len_tx_chk #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_short (tx_short),
    .tx_valid (tx_valid),
    .tx_ack   (tx_ack),
    .ser_out  (ser_out),
    .busy     (busy),
    .cnt      (cnt),
    .sreg     (sreg)
);

// File: tb/ser_dual_len_tx_bench.sv
module ser_dual_len_tx_bench;
    localparam int NWORDS = 144;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tx_word = '0;
    logic        tx_short = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_ack;
    logic        ser_out;

    int checks = 0;
    int errors = 0;

    logic q [0:63];
    int   head = 0;
    int   tail = 0;

    always #4 clk = ~clk;

    ser_dual_len_tx u_ser_dual_len_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_word  (tx_word),
        .tx_short (tx_short),
        .tx_valid (tx_valid),
        .tx_ack   (tx_ack),
        .ser_out  (ser_out)
    );

    function automatic logic [15:0] gen(int k);
        if (k % 24 == 0) return 16'hFFFF;
        if (k % 24 == 1) return 16'hF000;
        return 16'(k * 40503 + 12345) ^ 16'(k << 7);
    endfunction

    function automatic logic mode_of(int k);
        if (k < 24) return 1'b0;
        if (k < 48) return 1'b1;
        if (k < 96) return k[0];
        return gen(k + 7)[3];
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        int k;
        int cyc;
        int acks;
        logic exp_bit;
        logic exp_ack;
        string tag;
        k = 0;
        cyc = 0;
        acks = 0;

        // R1: reset with a word offered
        tx_valid = 1'b1;
        tx_word  = 16'hA5A5;
        repeat (3) begin
            @(negedge clk);
            check("R1 ser_out in reset", ser_out, 1'b0);
            check("R1 tx_ack in reset", tx_ack, 1'b0);
        end
        tx_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ser_out after reset", ser_out, 1'b0);
        check("R1 tx_ack after reset", tx_ack, 1'b0);

        while ((k < NWORDS || head != tail) && cyc < 10000) begin
            @(negedge clk);
            cyc++;
            // serial bit expected from the model queue
            if (head != tail) begin
                exp_bit = q[head % 64];
                head++;
                tag = (k <= 24) ? "R2 long bit" : (k <= 48) ? "R3 short bit" :
                      (k <= 96) ? "R6 alternating bit" : "R4 gapped bit";
            end else begin
                exp_bit = 1'b0;
                tag = "R7 idle low";
            end
            check(tag, ser_out, exp_bit);

            // drive inputs for this cycle
            if (k >= NWORDS || (k >= 96 && (cyc % 11) < 4)) begin
                tx_valid = 1'b0;
                tx_word  = 16'(cyc * 977);
                tx_short = cyc[0];
            end else begin
                tx_valid = 1'b1;
                tx_word  = gen(k);
                tx_short = mode_of(k);
            end
            #1;
            exp_ack = tx_valid && (head == tail);
            check("R5 tx_ack", tx_ack, exp_ack);
            if (tx_ack) begin
                acks++;
                if (tx_short) begin
                    for (int b = 11; b >= 0; b--) begin q[tail % 64] = tx_word[b]; tail++; end
                end else begin
                    for (int b = 15; b >= 0; b--) begin q[tail % 64] = tx_word[b]; tail++; end
                end
                k++;
            end
        end

        if (cyc >= 10000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: stream incomplete, words %0d expected %0d", k, NWORDS);
        end
        check("R7 idle after stream", ser_out, 1'b0);
        checks++;
        if (acks != NWORDS) begin
            errors++;
            $display("FAIL R4 ack count actual %0d expected %0d", acks, NWORDS);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule